// File: doc/BRIEF.md
# Granule Protection Table Walker

This block decides whether a physical access may proceed. It takes a physical address and the security space that issued it. It then walks a two-level protection table held in memory and reports either a pass or a classified fault. The table geometry is not fixed. The configuration word sets how many address bits are protected, how large each level 0 region is and the granule size, and from these the block derives the index slices and the alignment rules for each level.

Only one walk runs at a time. A request is accepted in `S_IDLE` when `req_valid_i` and `req_ready_o` are both high. At that point the address, space, configuration word, table base and implemented range are captured.

`S_CHECK` runs the pre-walk checks in this order:
- whether the block is enabled;
- whether the configuration is legal;
- whether the address fits in the protected size;
- whether the table base fits in the protected size.

After `S_CHECK` the walk either finishes at once (`S_CHECK -> S_DONE`) or issues the level 0 read (`S_CHECK -> S_L0_REQ -> S_L0_WAIT`). A level 0 table descriptor leads to a level 1 read (`S_L0_WAIT -> S_L1_REQ -> S_L1_WAIT`). A level 0 block descriptor, or any level 1 entry that is not a fault, leads to `S_PERM`, which decodes the 4-bit permission value. Every path ends in `S_DONE`. That state raises `res_valid_o` for one cycle and returns to `S_IDLE`. A read error or a malformed entry goes straight from either wait state to `S_DONE`.

Top module: `gpt_walker`

## Requirements
- R1: When the enable bit `cfg_i[0]` is 0, the request passes and no memory read is issued.
- R2: Configuration word layout: `[0]` enable, `[3:1]` protected-size code, `[5:4]` granule code, `[7:6]` shareability, `[9:8]` inner cacheability, `[11:10]` outer cacheability, `[15:12]` level 0 size field. The walk ends in a walk fault at level 0 with no read in any of these cases:
  - the protected-size code is greater than `pa_range_i`;
  - the shareability is 01;
  - the granule code is 11.
- R3: Shareability 10 is always accepted. Shareability 00 or 11 is a walk fault at level 0 only when both cacheability fields are 0.
- R4: Protected-size codes 0..6 give 32, 36, 40, 42, 44, 48 and 52 bits. If the address has a bit set at or above that size, a non-secure request (space 1) passes with no read, and any other space gets an address-size fault at level 0. This check comes after the configuration check and before the base check.
- R5: The table base is `tbr_i` shifted left by 12. A base with a bit at or above the protected size is an address-size fault. Otherwise its low max(pps − l0size + 3, 12) bits are cleared without any fault, where l0size = 30 + the level 0 size field.
- R6: The level 0 entry is read at base + 8 × addr[pps−1:l0size]. A read that returns `mem_err_i` gives an external-abort fault with the level of that read.
- R7: Level 0 entry types, taken from bits 3:0:
  - Type 1 is a block. Its bits 63:8 must be 0, and its permission value is bits 7:4.
  - Type 3 is a table. Its address is the entry with bits 3:0 cleared. That address must have no bit at or above pps and no bit below max(l0size − pgs − 1, 12).
  - Any other type, and any violated rule above, is a walk fault at level 0.
- R8: The level 1 entry is read at table + 8 × addr[l0size−1:pgs+4], where the granule code 00/01/10 gives pgs = 12/16/14.
  - Type 1 is contiguous. It needs bits 63:10 to be 0 and bits 9:8 to be non-zero, and its permission value is bits 7:4. A violation is a walk fault at level 1.
  - Any other entry holds 16 nibbles, and addr[pgs+3:pgs] selects one.
- R9: Permission decode, with space codes secure 0, non-secure 1, root 2 and realm 3:
  - 0000 is a fail.
  - 1111 passes any space.
  - 10xx passes only the space equal to xx, and is a fail for the others.
  - Any other value is a walk fault.
- R10: Each result carries the following fields:
  - a pass flag;
  - a fault class: fail 0, external abort 1, address size 2, walk 3;
  - the level reached;
  - the captured address and space.
- R11: `req_ready_o` is low from acceptance until the result pulse, and `res_valid_o` is high for exactly one cycle per accepted request. Each read is a one-cycle `mem_req_o` pulse, and the block waits for `mem_rvalid_i` before any further read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle if valid |
| req_addr_i | input | PA_W | Physical address to check |
| req_space_i | input | 2 | Security space of the request |
| cfg_i | input | 16 | Protection configuration word |
| tbr_i | input | PA_W-12 | Table base, in 4 KB units |
| pa_range_i | input | 3 | Implemented physical range code |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | PA_W | Read address of the 64-bit entry |
| mem_rvalid_i | input | 1 | Read response present |
| mem_err_i | input | 1 | Read response is an error |
| mem_rdata_i | input | 64 | Read data, little-endian 64-bit entry |
| res_valid_o | output | 1 | Result pulse |
| res_pass_o | output | 1 | Access allowed |
| res_class_o | output | 2 | Fault class |
| res_level_o | output | 1 | Level reached |
| res_addr_o | output | PA_W | Echoed address |
| res_space_o | output | 2 | Echoed space |

## Verification
The bench runs one fixed table image against many address and space pairs, so that one request set reaches a level 0 block, an invalid level 0 entry, a level 0 table with a misaligned base, a packed level 1 entry (one lookup per nibble) and contiguous level 1 entries. Comparing the fault class, the level and the number of reads for each request separates an early pre-walk exit from a one-level walk and from a two-level walk.

Configuration variants try out each illegal code and the shareability and cacheability pairings. Further cases set several fault conditions together (address and base both out of range, a bad configuration with an out-of-range address) to pin down the check order.

One case uses a table base whose low bit must be cleared silently, so that a walker which keeps that bit reads the wrong entry. A 64 KB granule case moves both index slices.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        GF_FAIL = 2'd0,
        GF_EABT = 2'd1,
        GF_SIZE = 2'd2,
        GF_WALK = 2'd3
    } gpt_fault_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_L0_REQ,
        S_L0_WAIT,
        S_L1_REQ,
        S_L1_WAIT,
        S_PERM,
        S_DONE
    } gpt_state_e;

    localparam logic [1:0] SP_SECURE = 2'd0;
    localparam logic [1:0] SP_NONSEC = 2'd1;
    localparam logic [1:0] SP_ROOT   = 2'd2;
    localparam logic [1:0] SP_REALM  = 2'd3;

    function automatic logic [6:0] pps_bits(input logic [2:0] code);
        case (code)
            3'd0:    pps_bits = 7'd32;
            3'd1:    pps_bits = 7'd36;
            3'd2:    pps_bits = 7'd40;
            3'd3:    pps_bits = 7'd42;
            3'd4:    pps_bits = 7'd44;
            3'd5:    pps_bits = 7'd48;
            default: pps_bits = 7'd52;
        endcase
    endfunction

endpackage

// File: rtl/gpt_cfg_decode.sv
module gpt_cfg_decode
    import gpt_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic [15:0]     cfg_i,
    input  logic [2:0]      pa_range_i,
    input  logic [PA_W-13:0] tbr_i,
    input  logic [PA_W-1:0] addr_i,
    output logic            en_o,
    output logic            cfg_bad_o,
    output logic            addr_over_o,
    output logic            base_over_o,
    output logic [6:0]      pgs_o,
    output logic [6:0]      l0sz_o,
    output logic [63:0]     pps_mask_o,
    output logic [63:0]     l0_mask_o,
    output logic [63:0]     l1_align_mask_o,
    output logic [63:0]     base_o
);

    logic [2:0]  pps_code;
    logic [1:0]  pgs_code, sh, irgn, orgn;
    logic [3:0]  l0_field;
    logic [6:0]  pps, al0, al1;
    logic        pgs_bad, sh_bad;
    logic [63:0] addr64, base_raw;

    assign pps_code = cfg_i[3:1];
    assign pgs_code = cfg_i[5:4];
    assign sh       = cfg_i[7:6];
    assign irgn     = cfg_i[9:8];
    assign orgn     = cfg_i[11:10];
    assign l0_field = cfg_i[15:12];

    always_comb begin
        en_o    = cfg_i[0];
        pps     = pps_bits(pps_code);
        pgs_bad = 1'b0;
        unique case (pgs_code)
            2'b00: pgs_o = 7'd12;
            2'b01: pgs_o = 7'd16;
            2'b10: pgs_o = 7'd14;
            default: begin
                pgs_o   = 7'd12;
                pgs_bad = 1'b1;
            end
        endcase
        sh_bad = (sh == 2'b01) ||
                 ((sh != 2'b10) && (irgn == 2'b00) && (orgn == 2'b00));
        cfg_bad_o = (pps_code > pa_range_i) || sh_bad || pgs_bad;

        l0sz_o     = 7'd30 + {3'b000, l0_field};
        pps_mask_o = (64'd1 << pps) - 64'd1;
        l0_mask_o  = (64'd1 << l0sz_o) - 64'd1;

        addr64      = 64'(addr_i);
        addr_over_o = |(addr64 & ~pps_mask_o);

        base_raw    = 64'({tbr_i, 12'h000});
        base_over_o = |(base_raw & ~pps_mask_o);
        al0    = ((pps + 7'd3) > (l0sz_o + 7'd12)) ? (pps + 7'd3 - l0sz_o) : 7'd12;
        base_o = base_raw & ~((64'd1 << al0) - 64'd1);

        al1 = (l0sz_o > (pgs_o + 7'd13)) ? (l0sz_o - pgs_o - 7'd1) : 7'd12;
        l1_align_mask_o = (64'd1 << al1) - 64'd1;
    end

endmodule

// File: rtl/gpt_perm_decode.sv
module gpt_perm_decode
    import gpt_pkg::*;
(
    input  logic [3:0] gpi_i,
    input  logic [1:0] space_i,
    output logic       allow_o,
    output logic       reserved_o
);

    always_comb begin
        allow_o    = 1'b0;
        reserved_o = 1'b0;
        if (gpi_i == 4'b1111) begin
            allow_o = 1'b1;
        end else if (gpi_i[3:2] == 2'b10) begin
            allow_o = (gpi_i[1:0] == space_i);
        end else if (gpi_i != 4'b0000) begin
            reserved_o = 1'b1;
        end
    end

endmodule

// File: rtl/gpt_walker.sv
module gpt_walker
    import gpt_pkg::*;
#(
    parameter int PA_W = 52
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [PA_W-1:0]  req_addr_i,
    input  logic [1:0]       req_space_i,
    input  logic [15:0]      cfg_i,
    input  logic [PA_W-13:0] tbr_i,
    input  logic [2:0]       pa_range_i,
    output logic             mem_req_o,
    output logic [PA_W-1:0]  mem_addr_o,
    input  logic             mem_rvalid_i,
    input  logic             mem_err_i,
    input  logic [63:0]      mem_rdata_i,
    output logic             res_valid_o,
    output logic             res_pass_o,
    output logic [1:0]       res_class_o,
    output logic             res_level_o,
    output logic [PA_W-1:0]  res_addr_o,
    output logic [1:0]       res_space_o
);

    gpt_state_e state_q, state_d;

    logic [PA_W-1:0]  addr_q, maddr_q, maddr_d;
    logic [1:0]       space_q;
    logic [15:0]      cfg_q;
    logic [PA_W-13:0] tbr_q;
    logic [2:0]       range_q;
    logic [3:0]       gpi_q, gpi_d;
    logic             pass_q, pass_d, lvl_q, lvl_d;
    gpt_fault_e       cls_q, cls_d;

    logic        dec_en, dec_cfg_bad, dec_addr_over, dec_base_over;
    logic [6:0]  dec_pgs, dec_l0sz;
    logic [63:0] dec_pps_mask, dec_l0_mask, dec_l1_al, dec_base;
    logic        perm_allow, perm_resv;

    logic [63:0] addr64, l0_entry_addr, l1_tbl, l1_entry_addr;
    logic [3:0]  nib_sel, packed_gpi;
    logic        accept;

    gpt_cfg_decode #(.PA_W(PA_W)) u_dec (
        .cfg_i          (cfg_q),
        .pa_range_i     (range_q),
        .tbr_i          (tbr_q),
        .addr_i         (addr_q),
        .en_o           (dec_en),
        .cfg_bad_o      (dec_cfg_bad),
        .addr_over_o    (dec_addr_over),
        .base_over_o    (dec_base_over),
        .pgs_o          (dec_pgs),
        .l0sz_o         (dec_l0sz),
        .pps_mask_o     (dec_pps_mask),
        .l0_mask_o      (dec_l0_mask),
        .l1_align_mask_o(dec_l1_al),
        .base_o         (dec_base)
    );

    gpt_perm_decode u_perm (
        .gpi_i     (gpi_q),
        .space_i   (space_q),
        .allow_o   (perm_allow),
        .reserved_o(perm_resv)
    );

    assign accept = req_valid_i && (state_q == S_IDLE);

    // index arithmetic for both levels
    always_comb begin
        addr64        = 64'(addr_q);
        l0_entry_addr = dec_base + (((addr64 & dec_pps_mask) >> dec_l0sz) << 3);
        l1_tbl        = mem_rdata_i & ~64'hF;
        l1_entry_addr = l1_tbl + (((addr64 & dec_l0_mask) >> (dec_pgs + 7'd4)) << 3);
        nib_sel       = 4'(addr64 >> dec_pgs);
        packed_gpi    = 4'(mem_rdata_i >> {nib_sel, 2'b00});
    end

    // next state and result bookkeeping
    always_comb begin
        state_d = state_q;
        maddr_d = maddr_q;
        gpi_d   = gpi_q;
        pass_d  = pass_q;
        lvl_d   = lvl_q;
        cls_d   = cls_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    state_d = S_CHECK;
                    pass_d  = 1'b0;
                    lvl_d   = 1'b0;
                    cls_d   = GF_FAIL;
                end
            end
            S_CHECK: begin
                state_d = S_DONE;
                if (!dec_en) begin
                    pass_d = 1'b1;
                end else if (dec_cfg_bad) begin
                    cls_d = GF_WALK;
                end else if (dec_addr_over) begin
                    if (space_q == SP_NONSEC) pass_d = 1'b1;
                    else                      cls_d  = GF_SIZE;
                end else if (dec_base_over) begin
                    cls_d = GF_SIZE;
                end else begin
                    maddr_d = PA_W'(l0_entry_addr);
                    state_d = S_L0_REQ;
                end
            end
            S_L0_REQ: state_d = S_L0_WAIT;
            S_L0_WAIT: begin
                if (mem_rvalid_i) begin
                    state_d = S_DONE;
                    cls_d   = GF_WALK;
                    if (mem_err_i) begin
                        cls_d = GF_EABT;
                    end else if (mem_rdata_i[3:0] == 4'd1) begin
                        if (mem_rdata_i[63:8] == '0) begin
                            gpi_d   = mem_rdata_i[7:4];
                            state_d = S_PERM;
                        end
                    end else if (mem_rdata_i[3:0] == 4'd3) begin
                        if (((l1_tbl & ~dec_pps_mask) == '0) &&
                            ((l1_tbl & dec_l1_al) == '0)) begin
                            maddr_d = PA_W'(l1_entry_addr);
                            lvl_d   = 1'b1;
                            state_d = S_L1_REQ;
                        end
                    end
                end
            end
            S_L1_REQ: state_d = S_L1_WAIT;
            S_L1_WAIT: begin
                if (mem_rvalid_i) begin
                    state_d = S_DONE;
                    if (mem_err_i) begin
                        cls_d = GF_EABT;
                    end else if (mem_rdata_i[3:0] == 4'd1) begin
                        if ((mem_rdata_i[63:10] != '0) || (mem_rdata_i[9:8] == 2'b00)) begin
                            cls_d = GF_WALK;
                        end else begin
                            gpi_d   = mem_rdata_i[7:4];
                            state_d = S_PERM;
                        end
                    end else begin
                        gpi_d   = packed_gpi;
                        state_d = S_PERM;
                    end
                end
            end
            S_PERM: begin
                state_d = S_DONE;
                if (perm_resv)       cls_d  = GF_WALK;
                else if (perm_allow) pass_d = 1'b1;
                else                 cls_d  = GF_FAIL;
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            maddr_q <= '0;
            gpi_q   <= '0;
            pass_q  <= 1'b0;
            lvl_q   <= 1'b0;
            cls_q   <= GF_FAIL;
            addr_q  <= '0;
            space_q <= '0;
            cfg_q   <= '0;
            tbr_q   <= '0;
            range_q <= '0;
        end else begin
            state_q <= state_d;
            maddr_q <= maddr_d;
            gpi_q   <= gpi_d;
            pass_q  <= pass_d;
            lvl_q   <= lvl_d;
            cls_q   <= cls_d;
            if (accept) begin
                addr_q  <= req_addr_i;
                space_q <= req_space_i;
                cfg_q   <= cfg_i;
                tbr_q   <= tbr_i;
                range_q <= pa_range_i;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready_o = (state_q == S_IDLE);
        mem_req_o   = (state_q == S_L0_REQ) || (state_q == S_L1_REQ);
        mem_addr_o  = maddr_q;
        res_valid_o = (state_q == S_DONE);
        res_pass_o  = pass_q;
        res_class_o = cls_q;
        res_level_o = lvl_q;
        res_addr_o  = addr_q;
        res_space_o = space_q;
    end

    // R1: a disabled configuration passes straight away
    p_disabled_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && !dec_en) |=> (res_valid_o && res_pass_o));

    // R2: illegal configuration is a level 0 walk fault
    p_cfg_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && dec_en && dec_cfg_bad) |=>
        (res_valid_o && !res_pass_o && res_class_o == GF_WALK && !res_level_o));

    // R4: non-secure address beyond the protected size passes
    p_ns_over_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && dec_en && !dec_cfg_bad && dec_addr_over &&
         space_q == SP_NONSEC) |=> (res_valid_o && res_pass_o));

    // R6: a read error ends the walk as an external abort
    p_eabt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_L0_WAIT || state_q == S_L1_WAIT) && mem_rvalid_i && mem_err_i) |=>
        (res_valid_o && !res_pass_o && res_class_o == GF_EABT));

    // R11: read requests are single-cycle pulses
    p_mem_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> (!mem_req_o && !res_valid_o));

    // R11: result pulse returns the walker to ready
    p_ready_after_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> (req_ready_o && !res_valid_o));

endmodule

// File: tb/gpt_walker_bench.sv
module gpt_walker_bench;

    localparam int PA_W = 52;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid_i = 1'b0;
    logic             req_ready_o;
    logic [PA_W-1:0]  req_addr_i = '0;
    logic [1:0]       req_space_i = '0;
    logic [15:0]      cfg_i = '0;
    logic [PA_W-13:0] tbr_i = '0;
    logic [2:0]       pa_range_i = '0;
    logic             mem_req_o;
    logic [PA_W-1:0]  mem_addr_o;
    logic             mem_rvalid_i = 1'b0;
    logic             mem_err_i = 1'b0;
    logic [63:0]      mem_rdata_i = '0;
    logic             res_valid_o, res_pass_o, res_level_o;
    logic [1:0]       res_class_o, res_space_o;
    logic [PA_W-1:0]  res_addr_o;

    gpt_walker #(.PA_W(PA_W)) u_gpt_walker (.*);

    always #5 clk = ~clk;

    typedef struct {
        string           tag;
        bit              pass;
        bit [1:0]        cls;
        bit              lvl;
        logic [PA_W-1:0] addr;
        bit [1:0]        sp;
        int              reads;
    } exp_t;

    exp_t exp_q[$];
    int total = 0, bad = 0, cyc = 0;
    int reads_total = 0, reads_mark = 0, pend = 0;
    logic [63:0] pend_addr;
    logic [63:0] mem [logic [63:0]];
    bit prev_valid = 0, finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] mkcfg(input bit en, input int pps, input int pgs,
                                          input int sh, input int ir, input int orr, input int l0f);
        return {4'(l0f), 2'(orr), 2'(ir), 2'(sh), 2'(pgs), 3'(pps), en};
    endfunction

    // memory model: two-cycle latency, error on two marked addresses
    always @(negedge clk) begin
        mem_rvalid_i = 1'b0;
        mem_err_i    = 1'b0;
        if (mem_req_o) begin
            reads_total++;
            pend_addr = 64'(mem_addr_o);
            pend = 2;
        end else if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rvalid_i = 1'b1;
                mem_err_i    = (pend_addr == 64'h200018) || (pend_addr == 64'h300000);
                mem_rdata_i  = mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid_o) begin
                chk(!prev_valid, "R11", "result pulse longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(res_pass_o == e.pass, e.tag, "pass", res_pass_o, e.pass);
                    if (!e.pass) begin
                        chk(res_class_o == e.cls, e.tag, "class", res_class_o, e.cls);
                        chk(res_level_o == e.lvl, e.tag, "level", res_level_o, e.lvl);
                    end
                    chk(res_addr_o == e.addr, "R10", "echo addr", res_addr_o, e.addr);
                    chk(res_space_o == e.sp, "R10", "echo space", res_space_o, e.sp);
                    chk((reads_total - reads_mark) == e.reads, e.tag, "read count",
                        reads_total - reads_mark, e.reads);
                end
                reads_mark = reads_total;
            end
            prev_valid = res_valid_o;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run(input string tag, input logic [PA_W-1:0] a, input logic [1:0] sp,
                       input logic [15:0] c, input logic [39:0] t, input logic [2:0] rg,
                       input bit ep, input bit [1:0] ec, input bit el, input int er);
        exp_t e;
        e.tag = tag; e.pass = ep; e.cls = ec; e.lvl = el; e.addr = a; e.sp = sp; e.reads = er;
        exp_q.push_back(e);
        do @(negedge clk); while (!req_ready_o);
        req_valid_i = 1'b1; req_addr_i = a; req_space_i = sp;
        cfg_i = c; tbr_i = t; pa_range_i = rg;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(!req_ready_o, "R11", "ready while busy", req_ready_o, 0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    localparam bit [1:0] C_FAIL = 0, C_EABT = 1, C_SIZE = 2, C_WALK = 3;

    initial begin
        logic [15:0] cb;
        cb = mkcfg(1, 0, 0, 2, 0, 0, 0);
        mem[64'h100000] = 64'hF1;
        mem[64'h100008] = 64'h91;
        mem[64'h100010] = 64'h200003;
        mem[64'h100018] = 64'h210003;
        mem[64'h200000] = 64'h5BA0F;
        mem[64'h200008] = 64'h181;
        mem[64'h200010] = 64'hF1;
        mem[64'h400008] = 64'h1F1;

        repeat (4) @(negedge clk);
        chk(req_ready_o == 1'b1, "R11", "reset ready", req_ready_o, 1);
        chk(res_valid_o == 1'b0, "R11", "reset result", res_valid_o, 0);
        chk(mem_req_o == 1'b0, "R11", "reset mem req", mem_req_o, 0);
        rst_n = 1'b1;

        run("R1", 52'h8000_1000, 0, mkcfg(0, 0, 0, 2, 0, 0, 0), 40'h100, 6, 1, 0, 0, 0);
        run("R7", 52'h0000_1000, 0, cb, 40'h100, 6, 1, 0, 0, 1);
        run("R9", 52'h4000_0000, 1, cb, 40'h100, 6, 1, 0, 0, 1);
        run("R9", 52'h4000_0000, 0, cb, 40'h100, 6, 0, C_FAIL, 0, 1);
        run("R8", 52'h8000_0000, 3, cb, 40'h100, 6, 1, 0, 0, 2);
        run("R8", 52'h8000_1000, 1, cb, 40'h100, 6, 0, C_FAIL, 1, 2);
        run("R9", 52'h8000_2000, 2, cb, 40'h100, 6, 1, 0, 0, 2);
        run("R9", 52'h8000_2000, 0, cb, 40'h100, 6, 0, C_FAIL, 1, 2);
        run("R9", 52'h8000_3000, 3, cb, 40'h100, 6, 1, 0, 0, 2);
        run("R9", 52'h8000_4000, 1, cb, 40'h100, 6, 0, C_WALK, 1, 2);
        run("R8", 52'h8001_0000, 0, cb, 40'h100, 6, 1, 0, 0, 2);
        run("R8", 52'h8001_0000, 1, cb, 40'h100, 6, 0, C_FAIL, 1, 2);
        run("R8", 52'h8002_0000, 0, cb, 40'h100, 6, 0, C_WALK, 1, 2);
        run("R6", 52'h8003_0000, 0, cb, 40'h100, 6, 0, C_EABT, 1, 2);
        run("R7", 52'hC000_0000, 0, cb, 40'h100, 6, 0, C_WALK, 0, 1);

        run("R2", 52'h1000, 0, mkcfg(1, 7, 0, 2, 0, 0, 0), 40'h100, 6, 0, C_WALK, 0, 0);
        run("R2", 52'h1000, 0, mkcfg(1, 1, 0, 2, 0, 0, 0), 40'h100, 0, 0, C_WALK, 0, 0);
        run("R2", 52'h1000, 0, mkcfg(1, 0, 0, 1, 1, 1, 0), 40'h100, 6, 0, C_WALK, 0, 0);
        run("R2", 52'h1000, 0, mkcfg(1, 0, 3, 2, 0, 0, 0), 40'h100, 6, 0, C_WALK, 0, 0);
        run("R3", 52'h1000, 0, mkcfg(1, 0, 0, 0, 0, 0, 0), 40'h100, 6, 0, C_WALK, 0, 0);
        run("R3", 52'h1000, 0, mkcfg(1, 0, 0, 0, 1, 0, 0), 40'h100, 6, 1, 0, 0, 1);
        run("R3", 52'h1000, 0, mkcfg(1, 0, 0, 3, 0, 1, 0), 40'h100, 6, 1, 0, 0, 1);
        run("R3", 52'h1000, 0, mkcfg(1, 0, 0, 3, 0, 0, 0), 40'h100, 6, 0, C_WALK, 0, 0);

        run("R4", 52'h1_0000_0000, 1, cb, 40'h100, 6, 1, 0, 0, 0);
        run("R4", 52'h1_0000_0000, 0, cb, 40'h100, 6, 0, C_SIZE, 0, 0);
        run("R4", 52'h1_0000_0000, 3, cb, 40'h100, 6, 0, C_SIZE, 0, 0);
        run("R4", 52'h1_0000_0000, 1, cb, 40'h100000, 6, 1, 0, 0, 0);
        run("R4", 52'h1_0000_0000, 1, mkcfg(1, 0, 3, 2, 0, 0, 0), 40'h100, 6, 0, C_WALK, 0, 0);
        run("R5", 52'h1000, 0, cb, 40'h100000, 6, 0, C_SIZE, 0, 0);
        run("R5", 52'h1000, 0, mkcfg(1, 2, 0, 2, 0, 0, 0), 40'h101, 6, 1, 0, 0, 1);

        run("R6", 52'h1000, 0, cb, 40'h300, 6, 0, C_EABT, 0, 1);
        run("R7", 52'h1000, 0, cb, 40'h400, 6, 0, C_WALK, 0, 1);
        run("R7", 52'h4000_0000, 0, cb, 40'h400, 6, 0, C_WALK, 0, 1);

        run("R8", 52'h8002_0000, 2, mkcfg(1, 0, 1, 2, 0, 0, 0), 40'h100, 6, 1, 0, 0, 2);
        run("R8", 52'h8001_0000, 1, mkcfg(1, 0, 1, 2, 0, 0, 0), 40'h100, 6, 0, C_FAIL, 1, 2);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule